// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Controller

This block sits beside a CPU bus. Each bus cycle opens with a one-clock strobe that carries the address. On that strobe the block compares the address with four programmable windows. Each window is given by a base-address register and a don't-care mask register. The winning window's active-low select line is held low for the rest of the cycle. The window's bus-width code is presented on an output, and the cycle is stretched by the window's programmed number of wait clocks. If no enabled window claims the address, no select line moves, and a separate fallback register supplies the width code and the wait count.

An external active-low wait request can hold the cycle open past the programmed count. The ready output rises only once the count has run out and the wait request is released. Ready ends the cycle, and the select line is dropped on the next clock. A select line reaches its pin only while that line's pin-enable bit is set. Software configures every register through a single write port addressed by a register index.

Top module: `cs_wait_unit`

## Requirements
- R1: After reset every select line is high (inactive), busReady is low, all windows are disabled, and every pin-enable bit is clear.
- R2: A window claims an address when every address bit whose mask bit is 0 equals the same bit of its base register. Address bits whose mask bit is 1 are ignored.
- R3: A window whose enable bit (control bit 0) is 0 never claims an address.
- R4: When several enabled windows claim one address, the lowest-numbered one wins, so at most one select line is low at any time.
- R5: An address claimed by no window drives no select line low. Its cycle takes its width code and wait count from the fallback register.
- R6: Select line i goes low only while pin-enable bit i is set; otherwise it stays high even though the window won.
- R7: From the clock after the strobe until the cycle ends, busWidth shows control bits 2:1 of the winning window, or of the fallback register.
- R8: With waitReqN held high, busReady is first high W clock edges after the strobe edge, where W is control bits 5:3 (0 to 7). W = 0 gives ready in the cycle right after the strobe edge.
- R9: busReady is never high while waitReqN is low. If waitReqN stays low past the count, ready rises in the same cycle that waitReqN returns high.
- R10: After a cycle in which busReady is high and no new strobe arrives, all select lines are high and busReady is low on the next cycle.
- R11: A strobe that arrives during an open cycle decodes the address again and restarts the wait count.
- R12: Register index map on cfgSel: window i uses index 4i for its base, 4i+1 for its mask and 4i+2 for its control. Index 16 is the fallback control register and index 17 holds the pin-enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write enable |
| cfgSel | input | 5 | Register index |
| cfgData | input | 24 | Register write data |
| busStart | input | 1 | One-clock bus-cycle strobe |
| busAddr | input | 24 | Bus address, valid with busStart |
| waitReqN | input | 1 | Active-low wait request |
| csN | output | 4 | Active-low window selects |
| busWidth | output | 2 | Width code of the open cycle |
| busReady | output | 1 | Cycle may complete |

## Verification
On every clock the assertions check these properties: no more than one select line is low, ready never coincides with an active wait request, and a cycle that completes releases both the select lines and ready on the next clock. Some behaviour can only be shown by the bench scenarios: which window wins a given address, the exact wait latency, the fallback settings, the pin gating and a restart part-way through a cycle. Address sweeps cover these, with the expected results computed from the programmed registers.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_BW_LSB = 1;
  localparam int BW_W = 2;
  localparam int CTL_WT_LSB = CTL_BW_LSB + BW_W;

  typedef struct packed {
    logic capture;
    logic drop;
  } csw_strobe_t;
endpackage

// File: rtl/csw_datapath.sv
module csw_datapath
  import csw_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_WIN = 4,
  parameter int WAIT_W  = 3,
  parameter int SEL_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] busAddr,
  input  csw_strobe_t       stb,
  output logic [WAIT_W-1:0] selWait,
  output logic [NUM_WIN-1:0] csN,
  output logic [BW_W-1:0]   busWidth
);
  localparam int CTL_W   = CTL_WT_LSB + WAIT_W;
  localparam int DEF_IDX = NUM_WIN * 4;
  localparam int PIN_IDX = NUM_WIN * 4 + 1;

  logic [ADDR_W-1:0]  baseReg [NUM_WIN];
  logic [ADDR_W-1:0]  maskReg [NUM_WIN];
  logic [CTL_W-1:0]   ctlReg  [NUM_WIN];
  logic [CTL_W-1:0]   defCtl;
  logic [NUM_WIN-1:0] pinEn;
  logic [NUM_WIN-1:0] hitVec;
  logic [NUM_WIN-1:0] winHot;
  logic [CTL_W-1:0]   winCtl;
  logic [NUM_WIN-1:0] curHot;
  logic [BW_W-1:0]    curWidth;

  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseReg[i] <= '0;
        maskReg[i] <= '0;
        ctlReg[i]  <= '0;
      end else if (cfgWe) begin
        if (cfgSel == SEL_W'(4 * i))     baseReg[i] <= cfgData;
        if (cfgSel == SEL_W'(4 * i + 1)) maskReg[i] <= cfgData;
        if (cfgSel == SEL_W'(4 * i + 2)) ctlReg[i]  <= cfgData[CTL_W-1:0];
      end
    end

    assign hitVec[i] = ctlReg[i][CTL_EN_BIT] &&
                       (((busAddr ^ baseReg[i]) & ~maskReg[i]) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defCtl <= '0;
      pinEn  <= '0;
    end else if (cfgWe) begin
      if (cfgSel == SEL_W'(DEF_IDX)) defCtl <= cfgData[CTL_W-1:0];
      if (cfgSel == SEL_W'(PIN_IDX)) pinEn  <= cfgData[NUM_WIN-1:0];
    end
  end

  // lowest index wins: scan downward so the smallest hit is written last
  always_comb begin
    winHot = '0;
    winCtl = defCtl;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        winHot    = '0;
        winHot[i] = 1'b1;
        winCtl    = ctlReg[i];
      end
    end
  end

  assign selWait = winCtl[CTL_WT_LSB +: WAIT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curHot   <= '0;
      curWidth <= '0;
    end else if (stb.capture) begin
      curHot   <= winHot;
      curWidth <= winCtl[CTL_BW_LSB +: BW_W];
    end else if (stb.drop) begin
      curHot   <= '0;
    end
  end

  assign csN      = ~(curHot & pinEn);
  assign busWidth = curWidth;
endmodule

// File: rtl/csw_control.sv
module csw_control
  import csw_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              waitReqN,
  input  logic [WAIT_W-1:0] loadWait,
  output csw_strobe_t       stb,
  output logic              busReady
);
  logic              active;
  logic [WAIT_W-1:0] waitCnt;

  assign busReady    = active && (waitCnt == '0) && waitReqN;
  assign stb.capture = busStart;
  assign stb.drop    = busReady && !busStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      waitCnt <= '0;
    end else if (busStart) begin
      active  <= 1'b1;
      waitCnt <= loadWait;
    end else if (active) begin
      if (busReady)            active  <= 1'b0;
      else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/cs_wait_unit.sv
module cs_wait_unit
  import csw_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_WIN = 4,
  parameter int WAIT_W  = 3,
  parameter int SEL_W   = $clog2(NUM_WIN * 4 + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [SEL_W-1:0]   cfgSel,
  input  logic [ADDR_W-1:0]  cfgData,
  input  logic               busStart,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               waitReqN,
  output logic [NUM_WIN-1:0] csN,
  output logic [BW_W-1:0]    busWidth,
  output logic               busReady
);
  csw_strobe_t       stb;
  logic [WAIT_W-1:0] selWait;

  csw_datapath #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WAIT_W(WAIT_W), .SEL_W(SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .busAddr(busAddr), .stb(stb), .selWait(selWait), .csN(csN), .busWidth(busWidth)
  );

  csw_control #(.WAIT_W(WAIT_W)) uCtl (
    .clk(clk), .rstN(rstN), .busStart(busStart), .waitReqN(waitReqN),
    .loadWait(selWait), .stb(stb), .busReady(busReady)
  );
endmodule

// File: rtl/csw_checker.sv
module csw_checker #(
  parameter int NUM_WIN = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busStart,
  input logic               waitReqN,
  input logic [NUM_WIN-1:0] csN,
  input logic               busReady
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R4
  AST_READY_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> waitReqN); // R9
  AST_READY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && !busStart) |=> !busReady); // R10
  AST_SELECT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && !busStart) |=> (csN == '1)); // R10
endmodule

bind cs_wait_unit csw_checker #(.NUM_WIN(NUM_WIN)) uChk (
  .clk(clk), .rstN(rstN), .busStart(busStart), .waitReqN(waitReqN),
  .csN(csN), .busReady(busReady)
);

// File: tb/sim_cs_wait_unit.sv
module sim_cs_wait_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgSel = '0;
  logic [23:0] cfgData = '0;
  logic busStart = 1'b0;
  logic [23:0] busAddr = '0;
  logic waitReqN = 1'b1;
  logic [3:0] csN;
  logic [1:0] busWidth;
  logic busReady;

  int total = 0;
  int bad = 0;
  int mBase[4], mMask[4], mCtl[4];
  int mDef = 0;
  int mPin = 0;

  always #10 clk = ~clk;

  cs_wait_unit u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .busStart(busStart), .busAddr(busAddr), .waitReqN(waitReqN),
    .csN(csN), .busWidth(busWidth), .busReady(busReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 5'(sel); cfgData = 24'(data);
    @(negedge clk);
    cfgWe = 1'b0;
    if (sel < 16) begin
      if (sel % 4 == 0) mBase[sel/4] = data;
      if (sel % 4 == 1) mMask[sel/4] = data;
      if (sel % 4 == 2) mCtl[sel/4] = data;
    end
    if (sel == 16) mDef = data;
    if (sel == 17) mPin = data;
  endtask

  function automatic int winOf(input int a);
    for (int i = 0; i < 4; i++)
      if ((mCtl[i] & 1) != 0 && (((a ^ mBase[i]) & ~mMask[i]) & 24'hFFFFFF) == 0)
        return i;
    return -1;
  endfunction

  // runs one bus cycle; holds waitReqN low for the first lowCnt sample points
  task automatic runCycle(input int a, input int lowCnt, input string tag);
    int w, ctl, expCs, expLat, n;
    w = winOf(a);
    ctl = (w < 0) ? mDef : mCtl[w];
    expCs = (w < 0) ? 4'hF : (~((1 << w) & mPin) & 4'hF);
    expLat = (ctl >> 3) & 7;
    if (lowCnt > expLat) expLat = lowCnt;
    @(negedge clk);
    busAddr = 24'(a); busStart = 1'b1; waitReqN = (lowCnt == 0);
    @(negedge clk);
    busStart = 1'b0;
    #1;
    check(csN == 4'(expCs), {tag, " R2/R3/R4/R5/R6 select"}, int'(csN), expCs);
    check(busWidth == 2'((ctl >> 1) & 3), {tag, " R7 width"}, int'(busWidth), (ctl >> 1) & 3);
    n = 0;
    while (!busReady && n < 40) begin
      @(negedge clk);
      n++;
      waitReqN = (n >= lowCnt);
      #1;
    end
    check(n == expLat, {tag, " R8/R9 latency"}, n, expLat);
    @(negedge clk);
    waitReqN = 1'b1;
    #1;
    check(csN == 4'hF && !busReady, {tag, " R10 release"}, {busReady, csN}, 15);
  endtask

  initial begin
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mBase[i] = 0; mMask[i] = 0; mCtl[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check(csN == 4'hF && !busReady, "R1 reset outputs", {busReady, csN}, 15);
    rstN = 1'b1;
    // R1: windows disabled after reset, so every address takes the fallback (zero wait)
    runCycle(24'h40, 0, "R1 post-reset");
    // configuration (R12 register map)
    wr(0, 24'h40);  wr(1, 24'h00000F); wr(2, (1 << 3) | (1 << 1) | 1);
    wr(4, 24'h00);  wr(5, 24'hFFFF7F); wr(6, (3 << 3) | (0 << 1) | 1);
    wr(8, 24'hC0);  wr(9, 24'hFFFF1F); wr(10, (5 << 3) | (2 << 1) | 1);
    wr(12, 24'hE0); wr(13, 24'hFFFF1F); wr(14, (7 << 3) | (1 << 1) | 0);
    wr(16, (2 << 3) | (3 << 1));
    wr(17, 4'b0111);
    for (int a = 0; a < 256; a++) runCycle(a, 0, "sweep1");
    // enable window 3 and its pin
    wr(14, (7 << 3) | (1 << 1) | 1);
    wr(17, 4'b1111);
    for (int a = 0; a < 256; a++) runCycle(a, 0, "sweep2");
    // R6: clear pin enable of window 2
    wr(17, 4'b1011);
    runCycle(24'hC4, 0, "R6 gated");
    // R9: wait request held beyond and within the count
    for (int l = 1; l < 10; l++) runCycle(24'hC4, l, "R9 hold");
    for (int l = 1; l < 10; l++) runCycle(24'h05, l, "R9 hold2");
    // R12: fallback register index changes unmatched latency
    wr(16, (4 << 3) | (1 << 1));
    wr(14, (7 << 3) | (1 << 1));
    runCycle(24'hE3, 0, "R12 fallback");
    // R11: restart during an open cycle
    @(negedge clk);
    busAddr = 24'hC8; busStart = 1'b1;
    @(negedge clk); busStart = 1'b0;
    @(negedge clk);
    #1;
    check(!busReady, "R11 still waiting", int'(busReady), 0);
    busAddr = 24'h42; busStart = 1'b1;
    @(negedge clk); busStart = 1'b0;
    #1;
    check(csN == 4'b1110, "R11 re-decode", int'(csN), 14);
    check(!busReady, "R11 restarted count", int'(busReady), 0);
    @(negedge clk);
    #1;
    check(busReady, "R11 new latency", int'(busReady), 1);
    @(negedge clk);
    #1;
    check(csN == 4'hF, "R11 release", int'(csN), 15);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule